// File: doc/BRIEF.md
# Non-Volatile Configuration Word Controller

This block gives a host register-level access to a small store of configuration words that models a non-volatile memory. The host writes a command word holding an opcode and a word address into a command register. It then polls a busy flag in that same register. Depending on the operation, it reads the result from a data register or places the value to be programmed there beforehand. Every operation holds the busy flag for a set number of cycles. Read and control operations take `READ_CYCLES` and `CTRL_CYCLES`, and program operations take `PROG_CYCLES`. A new command is only taken once the flag has dropped.

Programming is protected by a sticky write-enable latch. A write or erase issued while the latch is clear runs for its full busy time but leaves the store untouched. Reset clears the latch, empties the data register and reloads every word from a parameter image. In that image, word 3 carries a product identifier and words 10 to 12 carry a 48-bit station address, high byte first in each word.

The controller is a single state machine. Its states are `ST_IDLE`, `ST_READ`, `ST_WRITE`, `ST_ERASE`, `ST_WREN`, `ST_WRDIS` and `ST_NOP`. An accepted command moves `ST_IDLE` to the state of its opcode and loads the busy timer. Each busy state returns to `ST_IDLE` in the cycle its timer reaches zero, and it applies its effect on that same edge: a load, a program, a latch set or a latch clear.

Top module: `nvcfg_ctrl`

## Requirements
- R1: Reset has the following effects:
  - the busy flag reads 0;
  - the data register reads 0;
  - the command readback reads 0;
  - the write-enable latch is cleared;
  - every store word returns to its image value, with any operation in flight abandoned.
- R2: A write to the command register (offset 0xA) while idle is accepted. Bit 15 of the command register then reads 1 from the next cycle for exactly the operation's busy time (read 4 cycles by default). Bits 7:0 read back the last accepted command and all other bits read 0.
- R3: Opcode 2 (bits 7:6 = 10) reads the word at the address in bits 5:0. When busy clears, the data register (offset 0xC) holds that word.
- R4: Command 0x30 (bits 7:6 = 00, bits 5:4 = 11) sets the write-enable latch after `CTRL_CYCLES`. With the latch set, opcode 1 (bits 7:6 = 01) stores the data register into the addressed word after `PROG_CYCLES` (32 by default).
- R5: With the latch set, opcode 3 (bits 7:6 = 11) sets the addressed word to 0xFFFF after `PROG_CYCLES`.
- R6: A write or erase issued while the latch is clear keeps busy for `PROG_CYCLES` and leaves the store and the data register unchanged.
- R7: Command 0x00 (bits 7:6 = 00, bits 5:4 = 00) clears the latch after `CTRL_CYCLES`. Sub-codes 01 and 10 under opcode 0 only hold busy for `CTRL_CYCLES`.
- R8: While busy, writes to the command register and to the data register are ignored: the busy time, command readback and data register are unaffected.
- R9: The reset image holds `PRODUCT_ID` in word 3 and `STATION_ADDR` in words 10 to 12, high byte first. Every other word i holds 0xC000 + i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | REG_AW | Register offset for the access |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the register at `reg_addr`, combinational |

## Verification
The bench aims at the following corner cases:
- **Unlatched program.** A write or erase without write-enable would corrupt the store if the gate were missing, so the word is read back after each blocked attempt.
- **Command during busy.** A command or data write issued mid-operation would restart the timer, change the readback or overwrite a pending read result in a design that accepted it. The bench measures the remaining busy time and checks the data afterwards.
- **Address boundaries.** Words 0 and 63 are exercised, along with the image words for the identifier and station address.
- **Reset during a program.** A reset in the middle of a program operation must abandon it and clear the latch.
- **Busy length.** The busy time is counted per operation, which catches timer off-by-one errors.

// File: rtl/nvcfg_pkg.sv
`timescale 1ns/1ps
package nvcfg_pkg;

    localparam int WORD_W    = 16;
    localparam int IMG_WORDS = 64;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_ERASE,
        ST_WREN,
        ST_WRDIS,
        ST_NOP
    } nv_state_t;

    typedef enum logic [2:0] {
        OP_READ,
        OP_WRITE,
        OP_ERASE,
        OP_WREN,
        OP_WRDIS,
        OP_NOP
    } nv_op_t;

    // Builds the power-up image: identifier, station address, filler pattern.
    function automatic logic [IMG_WORDS-1:0][WORD_W-1:0] build_image(
        input logic [WORD_W-1:0] prod_id,
        input logic [47:0]       station
    );
        logic [IMG_WORDS-1:0][WORD_W-1:0] img;
        for (int i = 0; i < IMG_WORDS; i++) begin
            img[i] = 16'hC000 | WORD_W'(i);
        end
        img[3]  = prod_id;
        img[10] = station[47:32];
        img[11] = station[31:16];
        img[12] = station[15:0];
        return img;
    endfunction

endpackage

// File: rtl/nvcfg_decode.sv
`timescale 1ns/1ps
module nvcfg_decode
    import nvcfg_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic [7:0]    cmd,
    output nv_op_t        op,
    output logic [AW-1:0] addr
);

    always_comb begin
        unique case (cmd[7:6])
            2'b10: op = OP_READ;
            2'b01: op = OP_WRITE;
            2'b11: op = OP_ERASE;
            default: begin
                unique case (cmd[5:4])
                    2'b11:   op = OP_WREN;
                    2'b00:   op = OP_WRDIS;
                    default: op = OP_NOP;
                endcase
            end
        endcase
    end

    assign addr = cmd[AW-1:0];

endmodule

// File: rtl/nvcfg_timer.sv
`timescale 1ns/1ps
module nvcfg_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (count != '0) begin
            count <= count - 1'b1;
        end
    end

    assign done = (count == '0);

endmodule

// File: rtl/nvcfg_store.sv
`timescale 1ns/1ps
module nvcfg_store
    import nvcfg_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = 6,
    parameter logic [IMG_WORDS-1:0][WORD_W-1:0] INIT_IMAGE = '0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [AW-1:0]                waddr,
    input  logic [WORD_W-1:0]            wdata,
    input  logic [AW-1:0]                raddr,
    output logic [WORD_W-1:0]            rdata,
    output logic [DEPTH-1:0][WORD_W-1:0] image
);

    logic [WORD_W-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[i] <= INIT_IMAGE[i];
            end else if (we && (waddr == AW'(i))) begin
                mem[i] <= wdata;
            end
        end
        assign image[i] = mem[i];
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/nvcfg_ctrl.sv
`timescale 1ns/1ps
module nvcfg_ctrl
    import nvcfg_pkg::*;
#(
    parameter int          DEPTH        = 64,
    parameter int          READ_CYCLES  = 4,
    parameter int          PROG_CYCLES  = 32,
    parameter int          CTRL_CYCLES  = 4,
    parameter int          REG_AW       = 4,
    parameter int          CMD_OFF      = 'hA,
    parameter int          DATA_OFF     = 'hC,
    parameter logic [15:0] PRODUCT_ID   = 16'h6A17,
    parameter logic [47:0] STATION_ADDR = 48'h021C_5E33_804D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata
);

    localparam int AW      = $clog2(DEPTH);
    localparam int MAX_CYC = (PROG_CYCLES > READ_CYCLES)
                           ? ((PROG_CYCLES > CTRL_CYCLES) ? PROG_CYCLES : CTRL_CYCLES)
                           : ((READ_CYCLES > CTRL_CYCLES) ? READ_CYCLES : CTRL_CYCLES);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(READ_CYCLES - 1);
    localparam logic [CNT_W-1:0] PG_LOAD   = CNT_W'(PROG_CYCLES - 1);
    localparam logic [CNT_W-1:0] CT_LOAD   = CNT_W'(CTRL_CYCLES - 1);
    localparam logic [IMG_WORDS-1:0][WORD_W-1:0] IMAGE =
        build_image(PRODUCT_ID, STATION_ADDR);

    nv_state_t state, state_nx;

    logic              busy;
    logic              cmd_hit, data_hit, accept;
    nv_op_t            dec_op;
    logic [AW-1:0]     dec_addr;
    logic [AW-1:0]     op_addr;
    logic [7:0]        last_cmd;
    logic [15:0]       data_q;
    logic              wen_q;
    logic              tmr_load, tmr_done;
    logic [CNT_W-1:0]  tmr_val;
    logic              mem_we, rd_done, wen_set, wen_clr;
    logic [15:0]       mem_wdata, mem_rdata;
    logic [DEPTH-1:0][15:0] image;

    assign cmd_hit  = reg_wr && (reg_addr == REG_AW'(CMD_OFF));
    assign data_hit = reg_wr && (reg_addr == REG_AW'(DATA_OFF));
    assign busy     = (state != ST_IDLE);
    assign accept   = cmd_hit && !busy;

    nvcfg_decode #(.AW(AW)) u_decode (
        .cmd  (reg_wdata[7:0]),
        .op   (dec_op),
        .addr (dec_addr)
    );

    nvcfg_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    nvcfg_store #(
        .DEPTH      (DEPTH),
        .AW         (AW),
        .INIT_IMAGE (IMAGE)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (op_addr),
        .wdata (mem_wdata),
        .raddr (op_addr),
        .rdata (mem_rdata),
        .image (image)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next state and control outputs
    always_comb begin
        state_nx  = state;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        mem_we    = 1'b0;
        rd_done   = 1'b0;
        wen_set   = 1'b0;
        wen_clr   = 1'b0;
        mem_wdata = data_q;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    tmr_load = 1'b1;
                    unique case (dec_op)
                        OP_READ:  begin state_nx = ST_READ;  tmr_val = RD_LOAD; end
                        OP_WRITE: begin state_nx = ST_WRITE; tmr_val = PG_LOAD; end
                        OP_ERASE: begin state_nx = ST_ERASE; tmr_val = PG_LOAD; end
                        OP_WREN:  begin state_nx = ST_WREN;  tmr_val = CT_LOAD; end
                        OP_WRDIS: begin state_nx = ST_WRDIS; tmr_val = CT_LOAD; end
                        default:  begin state_nx = ST_NOP;   tmr_val = CT_LOAD; end
                    endcase
                end
            end
            ST_READ: begin
                if (tmr_done) begin
                    state_nx = ST_IDLE;
                    rd_done  = 1'b1;
                end
            end
            ST_WRITE: begin
                if (tmr_done) begin
                    state_nx = ST_IDLE;
                    mem_we   = wen_q;
                end
            end
            ST_ERASE: begin
                mem_wdata = 16'hFFFF;
                if (tmr_done) begin
                    state_nx = ST_IDLE;
                    mem_we   = wen_q;
                end
            end
            ST_WREN: begin
                if (tmr_done) begin
                    state_nx = ST_IDLE;
                    wen_set  = 1'b1;
                end
            end
            ST_WRDIS: begin
                if (tmr_done) begin
                    state_nx = ST_IDLE;
                    wen_clr  = 1'b1;
                end
            end
            ST_NOP: begin
                if (tmr_done) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Host-visible registers and write-enable latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_cmd <= '0;
            op_addr  <= '0;
            data_q   <= '0;
            wen_q    <= 1'b0;
        end else begin
            if (accept) begin
                last_cmd <= reg_wdata[7:0];
                op_addr  <= dec_addr;
            end
            if (rd_done) begin
                data_q <= mem_rdata;
            end else if (data_hit && !busy) begin
                data_q <= reg_wdata;
            end
            if (wen_set) begin
                wen_q <= 1'b1;
            end else if (wen_clr) begin
                wen_q <= 1'b0;
            end
        end
    end

    always_comb begin
        if (reg_addr == REG_AW'(CMD_OFF)) begin
            reg_rdata = {busy, 7'b0, last_cmd};
        end else if (reg_addr == REG_AW'(DATA_OFF)) begin
            reg_rdata = data_q;
        end else begin
            reg_rdata = '0;
        end
    end

endmodule

// File: rtl/nvcfg_ctrl_chk.sv
`timescale 1ns/1ps
module nvcfg_ctrl_chk #(
    parameter int DEPTH    = 64,
    parameter int REG_AW   = 4,
    parameter int CMD_OFF  = 'hA,
    parameter int DATA_OFF = 'hC
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [REG_AW-1:0]      reg_addr,
    input logic                   reg_wr,
    input logic                   busy,
    input logic [7:0]             last_cmd,
    input logic [15:0]            data_q,
    input logic                   wen_q,
    input logic                   rd_done,
    input logic [15:0]            mem_rdata,
    input logic [DEPTH-1:0][15:0] image
);

    logic cmd_w, data_w;
    assign cmd_w  = reg_wr && (reg_addr == REG_AW'(CMD_OFF));
    assign data_w = reg_wr && (reg_addr == REG_AW'(DATA_OFF));

    // R2
    busy_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_w && !busy |=> busy);

    // R2
    busy_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_w));

    // R8
    cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cmd_w |=> $stable(last_cmd));

    // R8
    data_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !rd_done && data_w |=> $stable(data_q));

    // R6
    locked_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wen_q |=> $stable(image));

    // R3
    read_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> (data_q == $past(mem_rdata)));

endmodule

bind nvcfg_ctrl nvcfg_ctrl_chk #(
    .DEPTH    (DEPTH),
    .REG_AW   (REG_AW),
    .CMD_OFF  (CMD_OFF),
    .DATA_OFF (DATA_OFF)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .busy      (busy),
    .last_cmd  (last_cmd),
    .data_q    (data_q),
    .wen_q     (wen_q),
    .rd_done   (rd_done),
    .mem_rdata (mem_rdata),
    .image     (image)
);

// File: tb/nvcfg_ctrl_tb.sv
`timescale 1ns/1ps
module nvcfg_ctrl_tb;

    localparam logic [3:0] CMD  = 4'hA;
    localparam logic [3:0] DATA = 4'hC;

    typedef struct packed {
        logic [7:0]  req;
        logic        set_data;
        logic [15:0] data;
        logic [15:0] cmd;
        logic [7:0]  cycles;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{8'd9, 1'b0, 16'h0000, 16'h0083, 8'd4,  16'h6A17}, // R9 R3 word 3
        '{8'd9, 1'b0, 16'h0000, 16'h008A, 8'd4,  16'h021C}, // R9 word 10
        '{8'd9, 1'b0, 16'h0000, 16'h008B, 8'd4,  16'h5E33}, // R9 word 11
        '{8'd9, 1'b0, 16'h0000, 16'h008C, 8'd4,  16'h804D}, // R9 word 12
        '{8'd6, 1'b1, 16'h1234, 16'h0045, 8'd32, 16'h1234}, // R6 write while locked
        '{8'd6, 1'b0, 16'h0000, 16'h0085, 8'd4,  16'hC005}, // R6 word 5 untouched
        '{8'd4, 1'b0, 16'h0000, 16'h0030, 8'd4,  16'hC005}, // R4 enable
        '{8'd4, 1'b1, 16'hBEEF, 16'h0045, 8'd32, 16'hBEEF}, // R4 write word 5
        '{8'd4, 1'b0, 16'h0000, 16'h0085, 8'd4,  16'hBEEF}, // R4 read back
        '{8'd5, 1'b0, 16'h0000, 16'h00C7, 8'd32, 16'hBEEF}, // R5 erase word 7
        '{8'd5, 1'b0, 16'h0000, 16'h0087, 8'd4,  16'hFFFF}, // R5 read erased
        '{8'd7, 1'b0, 16'h0000, 16'h0000, 8'd4,  16'hFFFF}, // R7 disable
        '{8'd7, 1'b0, 16'h0000, 16'h00C5, 8'd32, 16'hFFFF}, // R7 erase blocked
        '{8'd7, 1'b0, 16'h0000, 16'h0085, 8'd4,  16'hBEEF}, // R7 word 5 kept
        '{8'd3, 1'b0, 16'h0000, 16'h00BF, 8'd4,  16'hC03F}, // R3 top word 63
        '{8'd7, 1'b0, 16'h0000, 16'h0010, 8'd4,  16'hC03F}, // R7 sub-code 01 no-op
        '{8'd4, 1'b0, 16'h0000, 16'h0030, 8'd4,  16'hC03F}, // R4 enable again
        '{8'd4, 1'b1, 16'h0F0F, 16'h0040, 8'd32, 16'h0F0F}, // R4 write word 0
        '{8'd3, 1'b0, 16'h0000, 16'h0080, 8'd4,  16'h0F0F}  // R3 read word 0
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  reg_addr;
    logic        reg_wr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    nvcfg_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    task automatic chk(input int req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_addr  = CMD;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
        reg_addr = CMD;
        #0.1;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        reg_addr = CMD;
        #0.5;
        while (reg_rdata[15] && n < 1000) begin
            n++;
            @(negedge clk);
            #0.5;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL R2 watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int n;
        rst_n     = 1'b0;
        reg_wr    = 1'b0;
        reg_addr  = CMD;
        reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(CMD, v);  chk(1, "command readback after reset", v, 16'h0000);
        rd(DATA, v); chk(1, "data after reset", v, 16'h0000);
        rd(4'h4, v); chk(1, "unmapped offset", v, 16'h0000);
        @(negedge clk);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].set_data) wr(DATA, VEC[i].data);
            wr(CMD, VEC[i].cmd);
            count_busy(n);
            chk(int'(VEC[i].req), $sformatf("busy cycles vec %0d", i),
                16'(n), 16'(VEC[i].cycles));
            rd(DATA, v);
            chk(int'(VEC[i].req), $sformatf("data vec %0d", i), v, VEC[i].exp);
            @(negedge clk);
        end

        // R8 commands and data writes during busy are ignored (latch is set)
        wr(CMD, 16'h0083);
        wr(CMD, 16'h00C3);
        wr(DATA, 16'h5555);
        rd(CMD, v); chk(2, "readback low byte during busy", v, 16'h8083);
        count_busy(n);
        chk(8, "remaining busy after ignored writes", 16'(n), 16'd2);
        rd(DATA, v); chk(8, "data after ignored writes", v, 16'h6A17);
        @(negedge clk);
        wr(CMD, 16'h0083);
        count_busy(n);
        rd(DATA, v); chk(8, "word 3 not erased", v, 16'h6A17);
        @(negedge clk);

        // R1 reset during a program operation
        wr(DATA, 16'h7777);
        wr(CMD, 16'h0054);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        #0.5;
        rd(CMD, v); chk(1, "busy cleared by reset", v, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        wr(CMD, 16'h0094);
        count_busy(n);
        rd(DATA, v); chk(1, "aborted write left word 20", v, 16'hC014);
        @(negedge clk);
        wr(CMD, 16'h0080);
        count_busy(n);
        rd(DATA, v); chk(9, "word 0 restored by reset", v, 16'hC000);
        @(negedge clk);
        wr(DATA, 16'h1111);
        wr(CMD, 16'h0054);
        count_busy(n);
        chk(6, "blocked write busy after reset", 16'(n), 16'd32);
        @(negedge clk);
        wr(CMD, 16'h0094);
        count_busy(n);
        rd(DATA, v); chk(1, "latch cleared by reset", v, 16'hC014);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule